// File: doc/BRIEF.md
# Shared Search Window Center Clamp

This block sits between the motion predictor logic and four parallel block-matching engines that all read reference pixels from one common on-chip window. The common window is centered on the predictor of the largest (64x64) coding block and reaches a fixed range on every side of that block's footprint. The smaller engines (32x32, 16x16, 8x8) each bring their own predictor and their own block position inside the largest block. When such a predictor would make the engine search outside the common window, the block moves that engine's search center, independently on each axis, to the nearest spot where the engine's whole range and block footprint still fit.

Every lane passes its original predictor through unchanged, so the engine can still charge motion vector cost against the true predictor. Only the search center moves, so every engine visits the same number of candidates whether or not it was moved. A per-lane flag reports that the center was moved. All lanes are handled in parallel, with one output register stage.

Top module: `swin_center_clamp`

## Requirements
- R1: While rst_n is low at a rising clock edge, every out_vld and out_moved bit is 0 after that edge.
- R2: out_vld[e] equals eng_vld[e] from the previous clock edge (one cycle latency for every lane).
- R3: For a valid lane, out_pred_x[e] and out_pred_y[e] equal that lane's eng_pred_x[e] and eng_pred_y[e] from one cycle earlier, bit for bit.
- R4: For a valid lane whose predictor lies strictly inside its allowed center range on an axis, the output center on that axis equals the predictor.
- R5: Lane e has block size 64>>e (lane 0 is 64, lane 3 is 8), and eng_pos_x[e] is its unsigned pixel offset inside the largest block. With window range and engine range both 64, the allowed x center range is [root_mv_x - pos_x, root_mv_x + 64 - size - pos_x]; a predictor outside it is replaced by the nearer bound, in two's complement.
- R6: The y axis uses the same rule with root_mv_y and eng_pos_y, independently of the x result.
- R7: out_moved[e] is 1 exactly when a valid lane's output center differs from its predictor on at least one axis.
- R8: Lane 0 (the largest block at offset 0) always outputs the root predictor as its center, whatever its own predictor.
- R9: For a lane with eng_vld low, the registered center, predictor and moved outputs of that lane are all zero one cycle later.
- R10: A predictor lying exactly on either bound of its allowed range is kept, and the lane is not flagged as moved for that axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| root_mv_x | input | MV_W | Largest-block predictor, x (window center), signed |
| root_mv_y | input | MV_W | Largest-block predictor, y, signed |
| eng_vld | input | NUM_ENG | Per-lane request valid |
| eng_pred_x | input | NUM_ENG x MV_W | Per-lane predictor x, signed |
| eng_pred_y | input | NUM_ENG x MV_W | Per-lane predictor y, signed |
| eng_pos_x | input | NUM_ENG x POS_W | Per-lane block x offset inside the largest block |
| eng_pos_y | input | NUM_ENG x POS_W | Per-lane block y offset inside the largest block |
| out_vld | output | NUM_ENG | Per-lane result valid |
| out_ctr_x | output | NUM_ENG x MV_W | Adjusted search center x |
| out_ctr_y | output | NUM_ENG x MV_W | Adjusted search center y |
| out_pred_x | output | NUM_ENG x MV_W | Unmodified predictor x |
| out_pred_y | output | NUM_ENG x MV_W | Unmodified predictor y |
| out_moved | output | NUM_ENG | Center was changed on at least one axis |

## Verification
The x clamp and the y clamp of one lane can act in the same cycle, in opposite directions, and clamping on some lanes coincides with plain pass-through or invalid lanes on others. Directed cycles push one lane below its x range while above its y range, place predictors exactly on both bounds, and drop valid on a lane that carries an out-of-range predictor, followed by a long run of random roots, offsets and predictors. A behavioural model in the bench computes each lane's bounds from the stated formula and compares every output field on every clock, tagging each mismatch with the rule that applies to that lane and axis.

// File: rtl/swin_pkg.sv
// Package: shared definitions for the search window center clamp.
// Assumes the largest block size is a power of two and lanes are ordered
// from largest to smallest block.
package swin_pkg;

    // Result of limiting one axis of one lane.
    typedef enum logic [1:0] {
        LIM_PASS = 2'd0,
        LIM_LOW  = 2'd1,
        LIM_HIGH = 2'd2
    } lim_e;

    // Block size handled by lane idx: each lane halves the previous size.
    function automatic int lane_blk_size(input int lcu_size, input int idx);
        return lcu_size >> idx;
    endfunction

endpackage

// File: rtl/swin_axis_bounds.sv
// Module: swin_axis_bounds
// Computes, for one axis of one lane, the lowest and highest search center
// that keep the lane's full search range and block footprint inside the
// shared window. Assumes WIN_RANGE >= ENG_RANGE and pos + BLK_SIZE <= LCU_SIZE;
// results are EXT_W wide so no intermediate wraps.
module swin_axis_bounds #(
    parameter int MV_W      = 12,
    parameter int POS_W     = 6,
    parameter int EXT_W     = 14,
    parameter int LCU_SIZE  = 64,
    parameter int WIN_RANGE = 64,
    parameter int ENG_RANGE = 64,
    parameter int BLK_SIZE  = 64
) (
    input  logic [MV_W-1:0]         root,
    input  logic [POS_W-1:0]        pos,
    output logic signed [EXT_W-1:0] lo,
    output logic signed [EXT_W-1:0] hi
);
    localparam int LO_OFS = ENG_RANGE - WIN_RANGE;
    localparam int HI_OFS = WIN_RANGE - ENG_RANGE + LCU_SIZE - BLK_SIZE;
    localparam logic signed [EXT_W-1:0] LO_OFS_E = EXT_W'(LO_OFS);
    localparam logic signed [EXT_W-1:0] HI_OFS_E = EXT_W'(HI_OFS);

    logic signed [EXT_W-1:0] root_e;
    logic signed [EXT_W-1:0] pos_e;

    // Widen the root predictor (signed) and the block offset (unsigned).
    always_comb begin
        root_e = EXT_W'($signed(root));
        pos_e  = EXT_W'({1'b0, pos});
    end

    // Window edge minus engine reach minus block offset gives the bounds.
    always_comb begin
        lo = root_e + LO_OFS_E - pos_e;
        hi = root_e + HI_OFS_E - pos_e;
    end

endmodule

// File: rtl/swin_axis_limit.sv
// Module: swin_axis_limit
// Clamps one axis of a lane predictor to [lo, hi] and reports which side,
// if any, was applied. Assumes lo <= hi and that the clamped value fits in
// MV_W bits (the caller keeps the root predictor away from the MV limits).
module swin_axis_limit
    import swin_pkg::*;
#(
    parameter int MV_W  = 12,
    parameter int EXT_W = 14
) (
    input  logic [MV_W-1:0]         pred,
    input  logic signed [EXT_W-1:0] lo,
    input  logic signed [EXT_W-1:0] hi,
    output logic [MV_W-1:0]         ctr,
    output lim_e                    lim
);
    logic signed [EXT_W-1:0] pred_e;

    // Sign-extend the predictor for comparison with the bounds.
    always_comb pred_e = EXT_W'($signed(pred));

    // Pick the predictor or the nearer bound.
    always_comb begin
        if (pred_e < lo) begin
            ctr = lo[MV_W-1:0];
            lim = LIM_LOW;
        end else if (pred_e > hi) begin
            ctr = hi[MV_W-1:0];
            lim = LIM_HIGH;
        end else begin
            ctr = pred;
            lim = LIM_PASS;
        end
    end

endmodule

// File: rtl/swin_lane.sv
// Module: swin_lane
// One engine lane: bounds and clamp on both axes, plus the moved flag.
// Purely combinational; the top registers the results. Assumes the block
// offset is aligned so the block lies inside the largest block.
module swin_lane
    import swin_pkg::*;
#(
    parameter int MV_W      = 12,
    parameter int POS_W     = 6,
    parameter int EXT_W     = 14,
    parameter int LCU_SIZE  = 64,
    parameter int WIN_RANGE = 64,
    parameter int ENG_RANGE = 64,
    parameter int BLK_SIZE  = 64
) (
    input  logic [MV_W-1:0]  root_x,
    input  logic [MV_W-1:0]  root_y,
    input  logic [MV_W-1:0]  pred_x,
    input  logic [MV_W-1:0]  pred_y,
    input  logic [POS_W-1:0] pos_x,
    input  logic [POS_W-1:0] pos_y,
    output logic [MV_W-1:0]  ctr_x,
    output logic [MV_W-1:0]  ctr_y,
    output logic             moved
);
    logic signed [EXT_W-1:0] lo_x, hi_x, lo_y, hi_y;
    lim_e                    lim_x, lim_y;

    swin_axis_bounds #(
        .MV_W(MV_W), .POS_W(POS_W), .EXT_W(EXT_W), .LCU_SIZE(LCU_SIZE),
        .WIN_RANGE(WIN_RANGE), .ENG_RANGE(ENG_RANGE), .BLK_SIZE(BLK_SIZE)
    ) bnd_x_i (
        .root(root_x), .pos(pos_x), .lo(lo_x), .hi(hi_x)
    );

    swin_axis_bounds #(
        .MV_W(MV_W), .POS_W(POS_W), .EXT_W(EXT_W), .LCU_SIZE(LCU_SIZE),
        .WIN_RANGE(WIN_RANGE), .ENG_RANGE(ENG_RANGE), .BLK_SIZE(BLK_SIZE)
    ) bnd_y_i (
        .root(root_y), .pos(pos_y), .lo(lo_y), .hi(hi_y)
    );

    swin_axis_limit #(.MV_W(MV_W), .EXT_W(EXT_W)) lim_x_i (
        .pred(pred_x), .lo(lo_x), .hi(hi_x), .ctr(ctr_x), .lim(lim_x)
    );

    swin_axis_limit #(.MV_W(MV_W), .EXT_W(EXT_W)) lim_y_i (
        .pred(pred_y), .lo(lo_y), .hi(hi_y), .ctr(ctr_y), .lim(lim_y)
    );

    // A lane counts as moved when either axis left the pass-through path.
    always_comb moved = (lim_x != LIM_PASS) || (lim_y != LIM_PASS);

endmodule

// File: rtl/swin_center_clamp.sv
// Module: swin_center_clamp (top)
// Fits the search center of each of NUM_ENG parallel engines into one shared
// reference window centered on the largest block's predictor. Lane e works
// on blocks of LCU_SIZE >> e. The predictor is passed through untouched for
// cost use; only the center moves. One register stage, one cycle latency.
// Invalid lanes load zeros. Assumes root predictors leave at least
// WIN_RANGE + LCU_SIZE of headroom to the MV_W signed limits.
module swin_center_clamp
    import swin_pkg::*;
#(
    parameter int NUM_ENG   = 4,
    parameter int MV_W      = 12,
    parameter int LCU_SIZE  = 64,
    parameter int WIN_RANGE = 64,
    parameter int ENG_RANGE = 64,
    localparam int POS_W    = $clog2(LCU_SIZE),
    localparam int EXT_W    = MV_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [MV_W-1:0]                root_mv_x,
    input  logic [MV_W-1:0]                root_mv_y,
    input  logic [NUM_ENG-1:0]             eng_vld,
    input  logic [NUM_ENG-1:0][MV_W-1:0]   eng_pred_x,
    input  logic [NUM_ENG-1:0][MV_W-1:0]   eng_pred_y,
    input  logic [NUM_ENG-1:0][POS_W-1:0]  eng_pos_x,
    input  logic [NUM_ENG-1:0][POS_W-1:0]  eng_pos_y,
    output logic [NUM_ENG-1:0]             out_vld,
    output logic [NUM_ENG-1:0][MV_W-1:0]   out_ctr_x,
    output logic [NUM_ENG-1:0][MV_W-1:0]   out_ctr_y,
    output logic [NUM_ENG-1:0][MV_W-1:0]   out_pred_x,
    output logic [NUM_ENG-1:0][MV_W-1:0]   out_pred_y,
    output logic [NUM_ENG-1:0]             out_moved
);

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_lane
        localparam int BLK = lane_blk_size(LCU_SIZE, e);

        logic [MV_W-1:0] ctr_x_c, ctr_y_c;
        logic            moved_c;

        swin_lane #(
            .MV_W(MV_W), .POS_W(POS_W), .EXT_W(EXT_W), .LCU_SIZE(LCU_SIZE),
            .WIN_RANGE(WIN_RANGE), .ENG_RANGE(ENG_RANGE), .BLK_SIZE(BLK)
        ) lane_i (
            .root_x(root_mv_x),
            .root_y(root_mv_y),
            .pred_x(eng_pred_x[e]),
            .pred_y(eng_pred_y[e]),
            .pos_x (eng_pos_x[e]),
            .pos_y (eng_pos_y[e]),
            .ctr_x (ctr_x_c),
            .ctr_y (ctr_y_c),
            .moved (moved_c)
        );

        // Output stage: capture the lane result, or zeros when idle or in reset.
        always_ff @(posedge clk) begin
            if (!rst_n || !eng_vld[e]) begin
                out_vld[e]    <= 1'b0;
                out_ctr_x[e]  <= '0;
                out_ctr_y[e]  <= '0;
                out_pred_x[e] <= '0;
                out_pred_y[e] <= '0;
                out_moved[e]  <= 1'b0;
            end else begin
                out_vld[e]    <= 1'b1;
                out_ctr_x[e]  <= ctr_x_c;
                out_ctr_y[e]  <= ctr_y_c;
                out_pred_x[e] <= eng_pred_x[e];
                out_pred_y[e] <= eng_pred_y[e];
                out_moved[e]  <= moved_c;
            end
        end
    end

endmodule

// File: rtl/swin_center_clamp_chk.sv
// Module: swin_center_clamp_chk
// Checker bound to the top: watches ports across one register stage.
module swin_center_clamp_chk #(
    parameter int NUM_ENG = 4,
    parameter int MV_W    = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [MV_W-1:0]              root_mv_x,
    input logic [MV_W-1:0]              root_mv_y,
    input logic [NUM_ENG-1:0]           eng_vld,
    input logic [NUM_ENG-1:0][MV_W-1:0] eng_pred_x,
    input logic [NUM_ENG-1:0][MV_W-1:0] eng_pred_y,
    input logic [NUM_ENG-1:0]           out_vld,
    input logic [NUM_ENG-1:0][MV_W-1:0] out_ctr_x,
    input logic [NUM_ENG-1:0][MV_W-1:0] out_ctr_y,
    input logic [NUM_ENG-1:0][MV_W-1:0] out_pred_x,
    input logic [NUM_ENG-1:0][MV_W-1:0] out_pred_y,
    input logic [NUM_ENG-1:0]           out_moved
);
    logic armed;

    // Marks cycles whose previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (out_vld == '0) && (out_moved == '0)); // R1

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> out_vld == $past(eng_vld)); // R2

    AST_LCU_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(eng_vld[0]) |->
            (out_ctr_x[0] == $past(root_mv_x)) && (out_ctr_y[0] == $past(root_mv_y))); // R8

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_chk
        AST_PRED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            armed && $past(eng_vld[e]) |->
                (out_pred_x[e] == $past(eng_pred_x[e])) &&
                (out_pred_y[e] == $past(eng_pred_y[e]))); // R3

        AST_UNMOVED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[e] && !out_moved[e] |->
                (out_ctr_x[e] == out_pred_x[e]) && (out_ctr_y[e] == out_pred_y[e])); // R7

        AST_MOVED_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
            out_moved[e] |->
                (out_ctr_x[e] != out_pred_x[e]) || (out_ctr_y[e] != out_pred_y[e])); // R7

        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            armed && !$past(eng_vld[e]) |->
                !out_moved[e] && (out_ctr_x[e] == '0) && (out_ctr_y[e] == '0) &&
                (out_pred_x[e] == '0) && (out_pred_y[e] == '0)); // R9
    end

endmodule

bind swin_center_clamp swin_center_clamp_chk #(
    .NUM_ENG(NUM_ENG), .MV_W(MV_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .root_mv_x(root_mv_x), .root_mv_y(root_mv_y),
    .eng_vld(eng_vld), .eng_pred_x(eng_pred_x), .eng_pred_y(eng_pred_y),
    .out_vld(out_vld), .out_ctr_x(out_ctr_x), .out_ctr_y(out_ctr_y),
    .out_pred_x(out_pred_x), .out_pred_y(out_pred_y), .out_moved(out_moved)
);

// File: tb/swin_center_clamp_tb_top.sv
// Bench: behavioural model with expectation queues, compared every clock.
module swin_center_clamp_tb_top;
    localparam int NE  = 4;
    localparam int MW  = 12;
    localparam int LCU = 64;
    localparam int WR  = 64;
    localparam int ER  = 64;
    localparam int PW  = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [MW-1:0]        root_mv_x = '0, root_mv_y = '0;
    logic [NE-1:0]        eng_vld = '0;
    logic [NE-1:0][MW-1:0] eng_pred_x = '0, eng_pred_y = '0;
    logic [NE-1:0][PW-1:0] eng_pos_x = '0, eng_pos_y = '0;
    logic [NE-1:0]        out_vld, out_moved;
    logic [NE-1:0][MW-1:0] out_ctr_x, out_ctr_y, out_pred_x, out_pred_y;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    int    q_vld[$], q_cx[$], q_cy[$], q_px[$], q_py[$], q_mv[$];
    string q_tx[$], q_ty[$];

    always #2.5ns clk = ~clk;

    swin_center_clamp #(.NUM_ENG(NE), .MV_W(MW), .LCU_SIZE(LCU),
                        .WIN_RANGE(WR), .ENG_RANGE(ER)) dut_i (.*);

    function automatic int sx(input logic [MW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Model one axis: returns clamped center and a tag for the applying rule.
    task automatic model_axis(input int e, input int root, input int pos, input int pred,
                              input string clamp_tag, output int ctr, output string tag);
        int size, lo, hi;
        size = LCU >> e;
        lo = root - WR + ER - pos;
        hi = root + WR - ER + LCU - size - pos;
        ctr = (pred < lo) ? lo : (pred > hi) ? hi : pred;
        if (e == 0)                     tag = "R8";
        else if (pred == lo || pred == hi) tag = "R10";
        else if (ctr == pred)           tag = "R4";
        else                            tag = clamp_tag;
    endtask

    // Compare outputs of the last edge with the queued expectations.
    task automatic compare();
        for (int e = 0; e < NE; e++) begin
            int v, cx, cy, px, py, mv;
            string tx, ty;
            v = q_vld.pop_front(); cx = q_cx.pop_front(); cy = q_cy.pop_front();
            px = q_px.pop_front(); py = q_py.pop_front(); mv = q_mv.pop_front();
            tx = q_tx.pop_front(); ty = q_ty.pop_front();
            chk("R2", $sformatf("vld[%0d]", e), int'(out_vld[e]), v);
            chk(v ? "R3" : "R9", $sformatf("pred_x[%0d]", e), sx(out_pred_x[e]), px);
            chk(v ? "R3" : "R9", $sformatf("pred_y[%0d]", e), sx(out_pred_y[e]), py);
            chk(tx, $sformatf("ctr_x[%0d]", e), sx(out_ctr_x[e]), cx);
            chk(ty, $sformatf("ctr_y[%0d]", e), sx(out_ctr_y[e]), cy);
            chk(v ? "R7" : "R9", $sformatf("moved[%0d]", e), int'(out_moved[e]), mv);
        end
    endtask

    // Drive one cycle of stimulus and queue what the next edge must produce.
    task automatic drive(input int rx, input int ry, input bit [NE-1:0] vld,
                         input int px[NE], input int py[NE], input int ox[NE], input int oy[NE]);
        root_mv_x = MW'(rx); root_mv_y = MW'(ry); eng_vld = vld;
        for (int e = 0; e < NE; e++) begin
            int cx, cy;
            string tx, ty;
            eng_pred_x[e] = MW'(px[e]); eng_pred_y[e] = MW'(py[e]);
            eng_pos_x[e]  = PW'(ox[e]); eng_pos_y[e]  = PW'(oy[e]);
            model_axis(e, rx, ox[e], px[e], "R5", cx, tx);
            model_axis(e, ry, oy[e], py[e], "R6", cy, ty);
            if (vld[e]) begin
                q_vld.push_back(1); q_cx.push_back(cx); q_cy.push_back(cy);
                q_px.push_back(px[e]); q_py.push_back(py[e]);
                q_mv.push_back((cx != px[e] || cy != py[e]) ? 1 : 0);
                q_tx.push_back(tx); q_ty.push_back(ty);
            end else begin
                q_vld.push_back(0); q_cx.push_back(0); q_cy.push_back(0);
                q_px.push_back(0); q_py.push_back(0); q_mv.push_back(0);
                q_tx.push_back("R9"); q_ty.push_back("R9");
            end
        end
    endtask

    task automatic step(input int rx, input int ry, input bit [NE-1:0] vld,
                        input int px[NE], input int py[NE], input int ox[NE], input int oy[NE]);
        @(negedge clk);
        if (q_vld.size() != 0) compare();
        drive(rx, ry, vld, px, py, ox, oy);
    endtask

    initial begin
        int px[NE], py[NE], ox[NE], oy[NE];
        repeat (3) @(negedge clk);
        chk("R1", "out_vld in reset", int'(out_vld), 0);
        chk("R1", "out_moved in reset", int'(out_moved), 0);
        rst_n = 1'b1;

        // All inside: root 100/-40, offsets aligned.
        ox = '{0, 32, 16, 40}; oy = '{0, 0, 48, 8};
        px = '{100, 80, 90, 65}; py = '{-40, -20, -80, -45};
        step(100, -40, 4'b1111, px, py, ox, oy);
        // Opposite-direction clamps on one lane: x low, y high.
        px = '{100, 20, 10, -300}; py = '{-40, 200, 300, 900};
        step(100, -40, 4'b1111, px, py, ox, oy);
        // Exactly on bounds: lo = root - pos, hi = root + 64 - size - pos.
        px = '{100, 100 - 32, 100 + 64 - 16 - 16, 100 - 40};
        py = '{-40, -40 + 32, -40 - 48, -40 + 64 - 8 - 8};
        step(100, -40, 4'b1111, px, py, ox, oy);
        // Invalid lanes carrying out-of-range predictors; lane 0 off-root.
        px = '{500, 900, -900, 700}; py = '{-500, 800, -800, 600};
        step(-200, 300, 4'b0101, px, py, ox, oy);
        // Negative root, both axes high/low on different lanes.
        px = '{-1000, -1500, -700, -1300}; py = '{-1000, -700, -1400, -900};
        step(-1000, -1000, 4'b1111, px, py, ox, oy);

        // Random phase.
        for (int k = 0; k < 600; k++) begin
            int rx, ry;
            bit [NE-1:0] vld;
            rx = int'($urandom % 3001) - 1500;
            ry = int'($urandom % 3001) - 1500;
            for (int e = 0; e < NE; e++) begin
                int size;
                size = LCU >> e;
                vld[e] = ($urandom % 8) != 0;
                ox[e] = int'($urandom % (LCU / size)) * size;
                oy[e] = int'($urandom % (LCU / size)) * size;
                px[e] = rx + int'($urandom % 301) - 150;
                py[e] = ry + int'($urandom % 301) - 150;
                if ($urandom % 10 == 0) px[e] = rx - ox[e];
                if ($urandom % 10 == 0) py[e] = ry + LCU - size - oy[e];
            end
            step(rx, ry, vld, px, py, ox, oy);
        end
        px = '{0, 0, 0, 0}; py = px;
        step(0, 0, '0, px, py, ox, oy);
        @(negedge clk);
        compare();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(500us);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule